// File: doc/BRIEF.md
# Supply Backup Mode Controller

This block chooses whether the protected load runs from the main supply or from the backup cell, and sets the final level of every supervisor status output. Its inputs are comparator results that have already been reduced to clean logic flags: the main supply is under the reset threshold, the main supply is above the cell voltage (hysteresis already applied), the main supply is at least 4 V, the cell is healthy, and the power-fail monitor is clear. It also receives the unprocessed status values produced by the neighbouring supervisor blocks (low-supply warning, both reset polarities, watchdog fault, gated chip enable), plus the manual-reset and watchdog-kick inputs on their way to those blocks.

Backup operation needs both supply conditions together: the supply under the reset threshold and under the cell voltage. While it holds, the status outputs are pinned to a fixed safe pattern and the manual-reset and watchdog-kick inputs stop reaching the rest of the supervisor. The two supply-switch enables are sequenced so that one is always released a full cycle before the other is applied. All outputs are registered.

Top module: `bkup_ctrl`

## Requirements
- R1: Backup mode is requested only when `vcc_below_rst` is 1 and `vcc_above_bat` is 0; every other combination (including the supply under the reset threshold but still above the cell) keeps normal mode. A request is seen at the outputs on the first clock edge after it appears.
- R2: `bat_on` is 1 exactly while the cell switch enable `sel_bat` is 1, and 0 while the load is fed from the main supply.
- R3: `sel_main` and `sel_bat` are never 1 in the same cycle; on a mode change the active enable drops at the edge after the mode register changes and the other rises one edge later, leaving one cycle with both at 0.
- R4: In backup mode the status outputs are forced at the next edge to `low_warn_n`=0, `rst_n_o`=0, `rst_o`=1, `wdog_ok_n`=1 (no fault), `ce_o`=1.
- R5: In backup mode `mr_n_fwd` is held at 1 (no manual reset) whatever `mr_n` does.
- R6: In backup mode `wdi_fwd` holds the value it had on entry, so toggling `wdi` produces no edge downstream.
- R7: When `vcc_ge_4v` is 0, `pf_ok_o` and `bat_ok_o` are 0 at the next edge, in either mode.
- R8: When `vcc_ge_4v` is 1, `bat_ok_o` follows `bat_ok_raw` and `pf_ok_o` follows `pf_ok_raw` with one cycle of latency, in either mode.
- R9: In normal mode each of the five status outputs equals its raw source one cycle earlier.
- R10: With the supply above the cell voltage and above the reset threshold the block stays on the main supply with no switchover and no forced reset.
- R11: During synchronous reset `sel_main`=1, `sel_bat`=0, `bat_on`=0, status outputs hold the backup pattern of R4, `pf_ok_o`=`bat_ok_o`=0, `mr_n_fwd`=1, `wdi_fwd`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vcc_below_rst | input | 1 | Supply is under the reset threshold |
| vcc_above_bat | input | 1 | Supply is above the cell voltage (hysteresis applied) |
| vcc_ge_4v | input | 1 | Supply is at or above 4 V |
| bat_ok_raw | input | 1 | Cell is above its health threshold |
| pf_ok_raw | input | 1 | Power-fail monitor input is above its threshold |
| low_warn_raw_n | input | 1 | Unprocessed low-supply warning, active low |
| rst_n_raw | input | 1 | Unprocessed reset, active low |
| rst_raw | input | 1 | Unprocessed reset, active high |
| wdog_ok_raw_n | input | 1 | Unprocessed watchdog fault, active low |
| ce_raw | input | 1 | Unprocessed gated chip enable |
| mr_n | input | 1 | Manual reset request, active low |
| wdi | input | 1 | Watchdog kick input |
| sel_main | output | 1 | Main-supply switch enable |
| sel_bat | output | 1 | Cell switch enable |
| bat_on | output | 1 | Load is fed from the cell |
| low_warn_n | output | 1 | Final low-supply warning, active low |
| rst_n_o | output | 1 | Final reset, active low |
| rst_o | output | 1 | Final reset, active high |
| wdog_ok_n | output | 1 | Final watchdog fault, active low |
| ce_o | output | 1 | Final chip enable |
| pf_ok_o | output | 1 | Final power-fail status |
| bat_ok_o | output | 1 | Final cell health status |
| mr_n_fwd | output | 1 | Manual reset passed to the reset generator |
| wdi_fwd | output | 1 | Watchdog kick passed to the watchdog timer |

## Verification
The bench holds the supply under the reset threshold while keeping it above the cell; a design that tested only one of the two conditions would switch to the cell and force reset there. It flips the cell comparator every cycle or two while in the low-supply region, which would expose a sequencer that overlaps the two enables or skips the dead cycle. It toggles the manual-reset and kick inputs during backup, where a leaky gate would emit a reset request or a false kick edge, and it drops the 4 V flag in both modes, where a missing gate would let a stale health or power-fail value through.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  // status vector layout
  localparam int STAT_W   = 5;
  localparam int IDX_LOWW = 0;  // low-supply warning, active low
  localparam int IDX_RSTN = 1;  // reset, active low
  localparam int IDX_RST  = 2;  // reset, active high
  localparam int IDX_WDOK = 3;  // watchdog fault, active low
  localparam int IDX_CE   = 4;  // chip enable
  // level each status line takes in backup mode
  localparam logic [STAT_W-1:0] STAT_FORCED = 5'b11100;

  typedef struct packed {
    logic sel_main;
    logic sel_bat;
  } sw_sel_t;
endpackage

// File: rtl/bkup_mode_det.sv
module bkup_mode_det (
  input  logic clk,
  input  logic rst,
  input  logic vcc_below_rst,
  input  logic vcc_above_bat,
  output logic want_bkup,
  output logic mode_q
);
  // both conditions are required for backup
  assign want_bkup = vcc_below_rst & ~vcc_above_bat;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 1'b0;
    else     mode_q <= want_bkup;
  end
endmodule

// File: rtl/bkup_switch_seq.sv
module bkup_switch_seq
  import bkup_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    mode_q,
  output sw_sel_t sel_q
);
  sw_sel_t sel_d;

  // an enable may only rise once the opposite one is already low
  always_comb begin
    sel_d.sel_main = ~mode_q & ~sel_q.sel_bat;
    sel_d.sel_bat  =  mode_q & ~sel_q.sel_main;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q.sel_main <= 1'b1;
      sel_q.sel_bat  <= 1'b0;
    end else begin
      sel_q <= sel_d;
    end
  end
endmodule

// File: rtl/bkup_status_ovr.sv
module bkup_status_ovr #(
  parameter int               W      = 5,
  parameter logic [W-1:0]     FORCED = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         force_en,
  input  logic [W-1:0] raw,
  output logic [W-1:0] stat_q
);
  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst)           stat_q[i] <= FORCED[i];
      else if (force_en) stat_q[i] <= FORCED[i];
      else               stat_q[i] <= raw[i];
    end
  end
endmodule

// File: rtl/bkup_ctrl.sv
module bkup_ctrl
  import bkup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic vcc_below_rst,
  input  logic vcc_above_bat,
  input  logic vcc_ge_4v,
  input  logic bat_ok_raw,
  input  logic pf_ok_raw,
  input  logic low_warn_raw_n,
  input  logic rst_n_raw,
  input  logic rst_raw,
  input  logic wdog_ok_raw_n,
  input  logic ce_raw,
  input  logic mr_n,
  input  logic wdi,
  output logic sel_main,
  output logic sel_bat,
  output logic bat_on,
  output logic low_warn_n,
  output logic rst_n_o,
  output logic rst_o,
  output logic wdog_ok_n,
  output logic ce_o,
  output logic pf_ok_o,
  output logic bat_ok_o,
  output logic mr_n_fwd,
  output logic wdi_fwd
);
  logic              want_bkup;
  logic              mode_q;
  sw_sel_t           sel_q;
  logic [STAT_W-1:0] stat_raw;
  logic [STAT_W-1:0] stat_q;
  logic              bat_on_q;
  logic              pf_q, bok_q, mr_q, wdi_q;

  bkup_mode_det u_mode (
    .clk           (clk),
    .rst           (rst),
    .vcc_below_rst (vcc_below_rst),
    .vcc_above_bat (vcc_above_bat),
    .want_bkup     (want_bkup),
    .mode_q        (mode_q)
  );

  bkup_switch_seq u_sw (
    .clk    (clk),
    .rst    (rst),
    .mode_q (mode_q),
    .sel_q  (sel_q)
  );

  always_comb begin
    stat_raw           = '0;
    stat_raw[IDX_LOWW] = low_warn_raw_n;
    stat_raw[IDX_RSTN] = rst_n_raw;
    stat_raw[IDX_RST]  = rst_raw;
    stat_raw[IDX_WDOK] = wdog_ok_raw_n;
    stat_raw[IDX_CE]   = ce_raw;
  end

  bkup_status_ovr #(
    .W      (STAT_W),
    .FORCED (STAT_FORCED)
  ) u_ovr (
    .clk      (clk),
    .rst      (rst),
    .force_en (want_bkup),
    .raw      (stat_raw),
    .stat_q   (stat_q)
  );

  // battery-on indicator tracks the cell enable as its own flop
  always_ff @(posedge clk) begin
    if (rst) bat_on_q <= 1'b0;
    else     bat_on_q <= mode_q & ~sel_q.sel_main;
  end

  // status gated by the 4 V flag, and inputs blocked in backup
  always_ff @(posedge clk) begin
    if (rst) begin
      pf_q  <= 1'b0;
      bok_q <= 1'b0;
      mr_q  <= 1'b1;
      wdi_q <= 1'b0;
    end else begin
      pf_q  <= vcc_ge_4v & pf_ok_raw;
      bok_q <= vcc_ge_4v & bat_ok_raw;
      mr_q  <= want_bkup | mr_n;
      if (!want_bkup) wdi_q <= wdi;
    end
  end

  assign sel_main   = sel_q.sel_main;
  assign sel_bat    = sel_q.sel_bat;
  assign bat_on     = bat_on_q;
  assign low_warn_n = stat_q[IDX_LOWW];
  assign rst_n_o    = stat_q[IDX_RSTN];
  assign rst_o      = stat_q[IDX_RST];
  assign wdog_ok_n  = stat_q[IDX_WDOK];
  assign ce_o       = stat_q[IDX_CE];
  assign pf_ok_o    = pf_q;
  assign bat_ok_o   = bok_q;
  assign mr_n_fwd   = mr_q;
  assign wdi_fwd    = wdi_q;
endmodule

// File: rtl/bkup_ctrl_chk.sv
module bkup_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic vcc_below_rst,
  input logic vcc_above_bat,
  input logic vcc_ge_4v,
  input logic low_warn_raw_n,
  input logic rst_n_raw,
  input logic mr_n,
  input logic sel_main,
  input logic sel_bat,
  input logic bat_on,
  input logic low_warn_n,
  input logic rst_n_o,
  input logic rst_o,
  input logic wdog_ok_n,
  input logic ce_o,
  input logic pf_ok_o,
  input logic bat_ok_o,
  input logic mr_n_fwd
);
  assert_one_switch_R3: assert property (@(posedge clk) disable iff (rst)
    !(sel_main && sel_bat));

  assert_gap_before_bat_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_bat) |-> !$past(sel_main));

  assert_gap_before_main_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(sel_main) |-> !$past(sel_bat));

  assert_bat_on_tracks_R2: assert property (@(posedge clk) disable iff (rst)
    bat_on == sel_bat);

  assert_forced_state_R4: assert property (@(posedge clk) disable iff (rst)
    (vcc_below_rst && !vcc_above_bat) |=>
      (!low_warn_n && !rst_n_o && rst_o && wdog_ok_n && ce_o));

  assert_no_bkup_above_cell_R1: assert property (@(posedge clk) disable iff (rst)
    vcc_above_bat |=> (low_warn_n == $past(low_warn_raw_n) && rst_n_o == $past(rst_n_raw)));

  assert_mr_blocked_R5: assert property (@(posedge clk) disable iff (rst)
    (vcc_below_rst && !vcc_above_bat) |=> mr_n_fwd);

  assert_mr_passes_R9: assert property (@(posedge clk) disable iff (rst)
    !(vcc_below_rst && !vcc_above_bat) |=> (mr_n_fwd == $past(mr_n)));

  assert_low_supply_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !vcc_ge_4v |=> (!pf_ok_o && !bat_ok_o));
endmodule

bind bkup_ctrl bkup_ctrl_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .vcc_below_rst  (vcc_below_rst),
  .vcc_above_bat  (vcc_above_bat),
  .vcc_ge_4v      (vcc_ge_4v),
  .low_warn_raw_n (low_warn_raw_n),
  .rst_n_raw      (rst_n_raw),
  .mr_n           (mr_n),
  .sel_main       (sel_main),
  .sel_bat        (sel_bat),
  .bat_on         (bat_on),
  .low_warn_n     (low_warn_n),
  .rst_n_o        (rst_n_o),
  .rst_o          (rst_o),
  .wdog_ok_n      (wdog_ok_n),
  .ce_o           (ce_o),
  .pf_ok_o        (pf_ok_o),
  .bat_ok_o       (bat_ok_o),
  .mr_n_fwd       (mr_n_fwd)
);

// File: tb/bkup_ctrl_tb.sv
module bkup_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_below_rst = 1'b0, vcc_above_bat = 1'b1, vcc_ge_4v = 1'b1;
  logic bat_ok_raw = 1'b0, pf_ok_raw = 1'b0;
  logic low_warn_raw_n = 1'b1, rst_n_raw = 1'b1, rst_raw = 1'b0;
  logic wdog_ok_raw_n = 1'b1, ce_raw = 1'b0, mr_n = 1'b1, wdi = 1'b0;
  logic sel_main, sel_bat, bat_on, low_warn_n, rst_n_o, rst_o;
  logic wdog_ok_n, ce_o, pf_ok_o, bat_ok_o, mr_n_fwd, wdi_fwd;

  int errors = 0;
  int checks = 0;
  logic [15:0] lf = 16'hACE1;
  string sel_tag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  bkup_ctrl u_dut (
    .clk(clk), .rst(rst),
    .vcc_below_rst(vcc_below_rst), .vcc_above_bat(vcc_above_bat),
    .vcc_ge_4v(vcc_ge_4v), .bat_ok_raw(bat_ok_raw), .pf_ok_raw(pf_ok_raw),
    .low_warn_raw_n(low_warn_raw_n), .rst_n_raw(rst_n_raw), .rst_raw(rst_raw),
    .wdog_ok_raw_n(wdog_ok_raw_n), .ce_raw(ce_raw), .mr_n(mr_n), .wdi(wdi),
    .sel_main(sel_main), .sel_bat(sel_bat), .bat_on(bat_on),
    .low_warn_n(low_warn_n), .rst_n_o(rst_n_o), .rst_o(rst_o),
    .wdog_ok_n(wdog_ok_n), .ce_o(ce_o), .pf_ok_o(pf_ok_o), .bat_ok_o(bat_ok_o),
    .mr_n_fwd(mr_n_fwd), .wdi_fwd(wdi_fwd)
  );

  // reference model: expected state after each edge
  logic       m_mode, m_main, m_bat, m_bk, m_g4, m_pf, m_bok, m_mr, m_wdi;
  logic [4:0] m_stat;  // {ce, wdog_ok_n, rst, rst_n, low_warn_n}
  logic       m_want;
  assign m_want = vcc_below_rst && !vcc_above_bat;

  always @(posedge clk) begin
    if (rst) begin
      m_mode <= 0; m_main <= 1; m_bat <= 0; m_bk <= 1; m_g4 <= 0;
      m_stat <= 5'b11100; m_pf <= 0; m_bok <= 0; m_mr <= 1; m_wdi <= 0;
    end else begin
      m_mode <= m_want;
      m_bk   <= m_want;
      m_g4   <= vcc_ge_4v;
      if (m_mode) begin
        m_main <= 0;
        m_bat  <= !m_main;
      end else begin
        m_bat  <= 0;
        m_main <= !m_bat;
      end
      m_stat <= m_want ? 5'b11100 : {ce_raw, wdog_ok_raw_n, rst_raw, rst_n_raw, low_warn_raw_n};
      m_pf   <= vcc_ge_4v ? pf_ok_raw : 1'b0;
      m_bok  <= vcc_ge_4v ? bat_ok_raw : 1'b0;
      m_mr   <= m_want ? 1'b1 : mr_n;
      if (!m_want) m_wdi <= wdi;
    end
  end

  task automatic check(input logic [4:0] act, input logic [4:0] exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    string st_tag, g_tag;
    st_tag = rst ? "R11" : (m_bk ? "R4" : "R9");
    g_tag  = rst ? "R11" : (m_g4 ? "R8" : "R7");
    check({3'b0, sel_main, sel_bat}, {3'b0, m_main, m_bat}, sel_tag, "switch enables");
    check({4'b0, sel_main & sel_bat}, 5'b0, "R3", "both enables high");
    check({4'b0, bat_on}, {4'b0, m_bat}, "R2", "bat_on");
    check({ce_o, wdog_ok_n, rst_o, rst_n_o, low_warn_n}, m_stat, st_tag, "status");
    check({3'b0, pf_ok_o, bat_ok_o}, {3'b0, m_pf, m_bok}, g_tag, "pf/bat_ok");
    check({4'b0, mr_n_fwd}, {4'b0, m_mr}, m_bk ? "R5" : "R9", "mr_n_fwd");
    check({4'b0, wdi_fwd}, {4'b0, m_wdi}, m_bk ? "R6" : "R9", "wdi_fwd");
  endtask

  task automatic drive_raw();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    bat_ok_raw = lf[0]; pf_ok_raw = lf[1]; low_warn_raw_n = lf[2];
    rst_n_raw = lf[3]; rst_raw = lf[4]; wdog_ok_raw_n = lf[5];
    ce_raw = lf[6]; mr_n = lf[7]; wdi = lf[8];
  endtask

  // phase: 0 normal, 1 under threshold above cell, 2 backup,
  // 3 flicker, 4 below 4 V, 5 random
  task automatic run(input int n, input int phase, input string tag);
    sel_tag = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      drive_raw();
      case (phase)
        0: begin vcc_below_rst = 0; vcc_above_bat = lf[9]; vcc_ge_4v = 1; end
        1: begin vcc_below_rst = 1; vcc_above_bat = 1; vcc_ge_4v = lf[10]; end
        2: begin vcc_below_rst = 1; vcc_above_bat = 0; vcc_ge_4v = lf[10]; end
        3: begin vcc_below_rst = 1; vcc_above_bat = lf[9] & lf[11]; vcc_ge_4v = 1; end
        4: begin vcc_below_rst = lf[12]; vcc_above_bat = 1; vcc_ge_4v = 0; end
        default: begin
          vcc_below_rst = lf[12]; vcc_above_bat = lf[9]; vcc_ge_4v = lf[10];
        end
      endcase
    end
  endtask

  initial begin
    @(posedge clk);
    run(3, 0, "R11");            // reset held: reset state
    rst = 0;
    run(40, 0, "R10");           // supply above cell and threshold
    run(25, 1, "R1");            // under threshold but above cell: no backup
    run(40, 2, "R1");            // backup entry and hold, inputs toggling
    run(60, 3, "R3");            // fast mode flicker
    run(25, 4, "R7");            // supply under 4 V
    run(120, 5, "R3");           // everything random
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule